// File: doc/BRIEF.md
# Backplane Bus Slave Register File

This block is the control and monitoring port of a data-acquisition module on a parallel backplane bus. The bus uses 24-bit addresses and 32-bit data. A cycle is claimed only when three things are true: address bits 23..8 match a 16-bit base address set on board switches, the address-modifier code is one of the four standard single-cycle codes, and both the address and data strobes are high. Inside the 256-byte window the block serves a static configuration register, a control/status register, a reset register and a test port into the acquisition FIFO.

Each accepted access produces exactly one register update, FIFO push or FIFO pop, however long the master holds the data strobe. FIFO-port accesses are stalled while acquisition is busy: no acknowledge is given until busy drops, and a master that gives up first gets a bus time-out. The registers answer at all times. Offsets inside the window that hold no register are acknowledged harmlessly.

Top module: `bkpl_slave_regs`

## Requirements
- R1: A cycle is claimed only when the address modifier is 0x3E, 0x3D, 0x3A or 0x39. Any other code gets no acknowledge and has no effect.
- R2: A cycle is claimed only when address bits 23..8 equal `base_sw_i`. A mismatch in any bit gets no acknowledge.
- R3: `ack_o` rises on the first clock after a claimed strobe is sampled. It stays high while `ds_i` is held and falls on the first clock after `ds_i` drops. Each strobe performs its access exactly once.
- R4: Offset 0x00 is the configuration register. Write bits 4..0 set `delay_code_o`, bits 7..5 set `trig_delay_o`, bits 9..8 set `mode_o`, bits 23..16 set `low_lim_o` and bits 31..24 set `high_lim_o`. A read returns these fields in place, zero in bits 11..10, REVISION in bits 13..12 and VERSION in bits 15..14.
- R5: Writing offset 0x04 with bit 0 set gives a one-cycle `sw_trig_o` pulse. Bit 2 of the same write is stored as `trig_dis_o`.
- R6: Reading offset 0x04 returns the following bits: busy in bit 0, receiver-ready in bit 1, the disable bit in bit 2 and 0 in bit 3. Bits 15..4 carry the trigger count, bit 16 full, bit 17 empty, zeros in bits 19..18 and the FIFO count in bits 31..20.
- R7: Offset 0x08 is the reset register. Write bit 1 drives `rx_reset_o` and reads back in bit 1. Bit 0 reads 0. Writing 1 to bit 0 gives a one-cycle `mod_reset_o` pulse and clears every stored field, including `rx_reset_o`.
- R8: Writing offset 0x10 gives one `fifo_wr_o` pulse with the written word on `fifo_wdata_o`. Reading it returns `fifo_rdata_i` and gives one `fifo_rd_o` pulse.
- R9: While `busy_i` is high, accesses to offset 0x10 are not acknowledged and do not pulse the FIFO strobes. Register offsets are still served. A held FIFO access completes once busy falls.
- R10: Any other offset in the window is acknowledged. A read there returns zero, and a write there changes nothing.
- R11: After reset, `ack_o`, every pulse output and every stored field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address |
| am_i | input | 6 | Address-modifier code |
| as_i | input | 1 | Address strobe, active high |
| ds_i | input | 1 | Data strobe, active high |
| write_i | input | 1 | 1 = write cycle |
| wdata_i | input | 32 | Write data from master |
| rdata_o | output | 32 | Read data to master, valid with ack |
| ack_o | output | 1 | Data acknowledge |
| base_sw_i | input | 16 | Base address from four 4-bit switches |
| busy_i | input | 1 | Acquisition in progress |
| rx_ready_i | input | 1 | Timing receiver ready |
| trig_cnt_i | input | 12 | Trigger counter |
| fifo_full_i | input | 1 | FIFO full |
| fifo_empty_i | input | 1 | FIFO empty |
| fifo_cnt_i | input | 12 | FIFO word counter |
| fifo_rdata_i | input | 32 | FIFO head word |
| fifo_rd_o | output | 1 | FIFO pop pulse |
| fifo_wr_o | output | 1 | FIFO push pulse |
| fifo_wdata_o | output | 32 | FIFO push data |
| sw_trig_o | output | 1 | Software trigger pulse |
| trig_dis_o | output | 1 | External trigger disable |
| delay_code_o | output | 5 | Converter clock delay code |
| trig_delay_o | output | 3 | External trigger delay in clocks |
| mode_o | output | 2 | Acquisition mode |
| low_lim_o | output | 8 | Header low-level limit |
| high_lim_o | output | 8 | Header high-level limit |
| mod_reset_o | output | 1 | Module reset pulse |
| rx_reset_o | output | 1 | Timing receiver reset level |

## Verification
The bench holds the data strobe for several extra cycles. A design that re-armed its decode while the strobe was held would pop the FIFO or fire the trigger more than once. It also presents near-miss modifier codes and a base address that differs in one low bit, which a loose decode would claim. A FIFO read is started while busy and busy is released mid-strobe: a design that ignored busy would acknowledge early, and one that latched the refusal would hang. The module-reset write must clear the configuration without touching the fixed revision bits. Unmapped offsets must still acknowledge and read zero.

// File: rtl/bkpl_pkg.sv
package bkpl_pkg;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int BASE_W = 16;
  localparam int OFF_W  = ADDR_W - BASE_W;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CFG, SEL_CTL, SEL_RST, SEL_FIFO
  } sel_e;

  localparam logic [OFF_W-1:0] OFF_CFG  = 8'h00;
  localparam logic [OFF_W-1:0] OFF_CTL  = 8'h04;
  localparam logic [OFF_W-1:0] OFF_RST  = 8'h08;
  localparam logic [OFF_W-1:0] OFF_FIFO = 8'h10;

  function automatic logic am_ok(input logic [5:0] am);
    return (am == 6'h3E) || (am == 6'h3D) || (am == 6'h3A) || (am == 6'h39);
  endfunction
endpackage

// File: rtl/bkpl_decode.sv
module bkpl_decode
  import bkpl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [5:0]        am_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              busy_i,
  output logic              ready_o,
  output sel_e              sel_o
);
  logic hit;
  assign hit = am_ok(am_i) && (addr_i[ADDR_W-1:OFF_W] == base_i);

  always_comb begin
    unique case (addr_i[OFF_W-1:0])
      OFF_CFG:  sel_o = SEL_CFG;
      OFF_CTL:  sel_o = SEL_CTL;
      OFF_RST:  sel_o = SEL_RST;
      OFF_FIFO: sel_o = SEL_FIFO;
      default:  sel_o = SEL_NONE;
    endcase
  end

  // FIFO port stalls while acquisition owns the FIFO
  assign ready_o = hit && !(busy_i && (sel_o == SEL_FIFO));
endmodule

// File: rtl/bkpl_regs.sv
module bkpl_regs
  import bkpl_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd3,
  parameter logic [1:0] VERSION  = 2'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  sel_e              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              busy_i,
  input  logic              rx_ready_i,
  input  logic [11:0]       trig_cnt_i,
  input  logic              fifo_full_i,
  input  logic              fifo_empty_i,
  input  logic [11:0]       fifo_cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sw_trig_o,
  output logic              trig_dis_o,
  output logic [4:0]        delay_code_o,
  output logic [2:0]        trig_delay_o,
  output logic [1:0]        mode_o,
  output logic [7:0]        low_lim_o,
  output logic [7:0]        high_lim_o,
  output logic              mod_reset_o,
  output logic              rx_reset_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i[15:10];

  logic clr_all;
  assign clr_all = wr_i && (sel_i == SEL_RST) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_code_o <= '0;
      trig_delay_o <= '0;
      mode_o       <= '0;
      low_lim_o    <= '0;
      high_lim_o   <= '0;
      trig_dis_o   <= 1'b0;
      rx_reset_o   <= 1'b0;
      sw_trig_o    <= 1'b0;
      mod_reset_o  <= 1'b0;
    end else begin
      sw_trig_o   <= wr_i && (sel_i == SEL_CTL) && wdata_i[0];
      mod_reset_o <= clr_all;
      if (clr_all) begin
        delay_code_o <= '0;
        trig_delay_o <= '0;
        mode_o       <= '0;
        low_lim_o    <= '0;
        high_lim_o   <= '0;
        trig_dis_o   <= 1'b0;
        rx_reset_o   <= 1'b0;
      end else if (wr_i) begin
        case (sel_i)
          SEL_CFG: begin
            delay_code_o <= wdata_i[4:0];
            trig_delay_o <= wdata_i[7:5];
            mode_o       <= wdata_i[9:8];
            low_lim_o    <= wdata_i[23:16];
            high_lim_o   <= wdata_i[31:24];
          end
          SEL_CTL: trig_dis_o <= wdata_i[2];
          SEL_RST: rx_reset_o <= wdata_i[1];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CFG: rdata_o = {high_lim_o, low_lim_o, VERSION, REVISION, 2'b00,
                          mode_o, trig_delay_o, delay_code_o};
      SEL_CTL: rdata_o = {fifo_cnt_i, 2'b00, fifo_empty_i, fifo_full_i,
                          trig_cnt_i, 1'b0, trig_dis_o, rx_ready_i, busy_i};
      SEL_RST: rdata_o = {30'd0, rx_reset_o, 1'b0};
      default: rdata_o = '0;
    endcase
  end

  assert_cfg_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> ($stable(delay_code_o) && $stable(mode_o) && $stable(high_lim_o)));
  assert_trig_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trig_o |=> !sw_trig_o);
  assert_reset_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_reset_o |-> (!rx_reset_o && !trig_dis_o && mode_o == 2'b00));
endmodule

// File: rtl/bkpl_slave_regs.sv
module bkpl_slave_regs
  import bkpl_pkg::*;
#(
  parameter logic [1:0] REVISION = 2'd3,
  parameter logic [1:0] VERSION  = 2'd2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [23:0]        addr_i,
  input  logic [5:0]         am_i,
  input  logic               as_i,
  input  logic               ds_i,
  input  logic               write_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               ack_o,
  input  logic [15:0]        base_sw_i,
  input  logic               busy_i,
  input  logic               rx_ready_i,
  input  logic [11:0]        trig_cnt_i,
  input  logic               fifo_full_i,
  input  logic               fifo_empty_i,
  input  logic [11:0]        fifo_cnt_i,
  input  logic [31:0]        fifo_rdata_i,
  output logic               fifo_rd_o,
  output logic               fifo_wr_o,
  output logic [31:0]        fifo_wdata_o,
  output logic               sw_trig_o,
  output logic               trig_dis_o,
  output logic [4:0]         delay_code_o,
  output logic [2:0]         trig_delay_o,
  output logic [1:0]         mode_o,
  output logic [7:0]         low_lim_o,
  output logic [7:0]         high_lim_o,
  output logic               mod_reset_o,
  output logic               rx_reset_o
);
  sel_e              sel;
  logic              ready;
  logic              accept;
  logic [DATA_W-1:0] reg_rdata;

  bkpl_decode u_dec (
    .addr_i  (addr_i),
    .am_i    (am_i),
    .base_i  (base_sw_i),
    .busy_i  (busy_i),
    .ready_o (ready),
    .sel_o   (sel)
  );

  // one access per strobe: accept only from idle
  assign accept = !ack_o && as_i && ds_i && ready;

  bkpl_regs #(.REVISION(REVISION), .VERSION(VERSION)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (accept && write_i),
    .sel_i        (sel),
    .wdata_i      (wdata_i),
    .busy_i       (busy_i),
    .rx_ready_i   (rx_ready_i),
    .trig_cnt_i   (trig_cnt_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_empty_i (fifo_empty_i),
    .fifo_cnt_i   (fifo_cnt_i),
    .rdata_o      (reg_rdata),
    .sw_trig_o    (sw_trig_o),
    .trig_dis_o   (trig_dis_o),
    .delay_code_o (delay_code_o),
    .trig_delay_o (trig_delay_o),
    .mode_o       (mode_o),
    .low_lim_o    (low_lim_o),
    .high_lim_o   (high_lim_o),
    .mod_reset_o  (mod_reset_o),
    .rx_reset_o   (rx_reset_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o        <= 1'b0;
      rdata_o      <= '0;
      fifo_rd_o    <= 1'b0;
      fifo_wr_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      fifo_rd_o <= accept && !write_i && (sel == SEL_FIFO);
      fifo_wr_o <= accept && write_i && (sel == SEL_FIFO);
      if (accept) begin
        ack_o   <= 1'b1;
        rdata_o <= write_i ? '0 : ((sel == SEL_FIFO) ? fifo_rdata_i : reg_rdata);
        if (write_i && sel == SEL_FIFO) fifo_wdata_o <= wdata_i;
      end else if (!ds_i) begin
        ack_o <= 1'b0;
      end
    end
  end

  assert_am_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(am_i) == 6'h3E || $past(am_i) == 6'h3D ||
                      $past(am_i) == 6'h3A || $past(am_i) == 6'h39));
  assert_base_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> ($past(addr_i[23:8]) == $past(base_sw_i)));
  assert_ack_needs_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(as_i && ds_i));
  assert_ack_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !ds_i) |=> !ack_o);
  assert_one_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_rd_o, fifo_wr_o, sw_trig_o, mod_reset_o}));
  assert_fifo_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_rd_o || fifo_wr_o) |-> !$past(busy_i));
endmodule

// File: tb/tb_bkpl_slave_regs.sv
module tb_bkpl_slave_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [23:0] addr = '0;
  logic [5:0]  am = '0;
  logic        as_s = 1'b0, ds_s = 1'b0, wr = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        ack;
  logic [15:0] base = 16'hA5C3;
  logic        busy = 1'b0, rx_ready = 1'b0, full = 1'b0, empty = 1'b0;
  logic [11:0] tcnt = '0, fcnt = '0;
  logic [31:0] frd = '0, fwd;
  logic        frd_p, fwr_p, strig, tdis, mrst, rxrst;
  logic [4:0]  dcode;
  logic [2:0]  tdly;
  logic [1:0]  mode;
  logic [7:0]  llim, hlim;

  bkpl_slave_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .am_i(am), .as_i(as_s), .ds_i(ds_s),
    .write_i(wr), .wdata_i(wdata), .rdata_o(rdata), .ack_o(ack), .base_sw_i(base),
    .busy_i(busy), .rx_ready_i(rx_ready), .trig_cnt_i(tcnt), .fifo_full_i(full),
    .fifo_empty_i(empty), .fifo_cnt_i(fcnt), .fifo_rdata_i(frd), .fifo_rd_o(frd_p),
    .fifo_wr_o(fwr_p), .fifo_wdata_o(fwd), .sw_trig_o(strig), .trig_dis_o(tdis),
    .delay_code_o(dcode), .trig_delay_o(tdly), .mode_o(mode), .low_lim_o(llim),
    .high_lim_o(hlim), .mod_reset_o(mrst), .rx_reset_o(rxrst)
  );

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_trig = 0, n_mrst = 0;
  logic [31:0] last_fwd = '0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        ack_d = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pops on each read ack, counts strobe pulses
  always @(negedge clk) begin
    if (ack && !ack_d && !wr) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected read ack", rdata, 32'h0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
    ack_d = ack;
    if (frd_p) n_rd++;
    if (fwr_p) begin n_wr++; last_fwd = fwd; end
    if (strig) n_trig++;
    if (mrst) n_mrst++;
  end

  task automatic bus(input logic [7:0] off, input logic [5:0] amc, input logic w,
                     input logic [31:0] d, input logic [31:0] exp, input string tag,
                     input int hold);
    automatic bit got = 0;
    @(negedge clk);
    addr = {base, off}; am = amc; wr = w; wdata = d; as_s = 1; ds_s = 1;
    if (!w) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ack) begin got = 1; break; end
    end
    check(got, {tag, " R3 ack arrives"}, {31'd0, ack}, 32'd1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(ack, "R3 ack held with ds", {31'd0, ack}, 32'd1);
    end
    as_s = 0; ds_s = 0;
    @(negedge clk);
    check(!ack, "R3 ack released", {31'd0, ack}, 32'd0);
  endtask

  task automatic no_ack(input logic [23:0] a, input logic [5:0] amc, input logic w, input string tag);
    automatic bit seen = 0;
    @(negedge clk);
    addr = a; am = amc; wr = w; wdata = 32'hFFFF_FFFF; as_s = 1; ds_s = 1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (ack) seen = 1; end
    as_s = 0; ds_s = 0;
    @(negedge clk);
    check(!seen, tag, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    int snap;
    bit got;
    repeat (3) @(negedge clk);
    check({ack, frd_p, fwr_p, strig, tdis, mrst, rxrst} == 7'd0, "R11 reset outputs", {25'd0, ack, frd_p, fwr_p, strig, tdis, mrst, rxrst}, 0);
    check({dcode, tdly, mode, llim, hlim} == 0, "R11 reset fields", {dcode, tdly, mode, llim, hlim}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 configuration write/read
    bus(8'h00, 6'h3E, 1, 32'hC35A_FFFF, 0, "R4 wr", 0);
    check({hlim, llim, 3'd0, dcode, tdly, mode} == {8'hC3, 8'h5A, 3'd0, 5'h1F, 3'd7, 2'd3}, "R4 field outputs",
          {hlim, llim, 3'd0, dcode, tdly, mode}, {8'hC3, 8'h5A, 3'd0, 5'h1F, 3'd7, 2'd3});
    bus(8'h00, 6'h3E, 0, 0, 32'hC35A_B3FF, "R4 readback", 0);
    // R1 all four legal codes
    bus(8'h00, 6'h3D, 0, 0, 32'hC35A_B3FF, "R1 am 3D", 0);
    bus(8'h00, 6'h3A, 0, 0, 32'hC35A_B3FF, "R1 am 3A", 0);
    bus(8'h00, 6'h39, 0, 0, 32'hC35A_B3FF, "R1 am 39", 0);
    no_ack({base, 8'h00}, 6'h3B, 1, "R1 am 3B ignored");
    no_ack({base, 8'h00}, 6'h09, 1, "R1 am 09 ignored");
    check(dcode == 5'h1F && hlim == 8'hC3, "R1 no write effect", {19'd0, dcode, hlim}, {19'd0, 5'h1F, 8'hC3});
    // R2 base mismatch
    no_ack({base ^ 16'h0001, 8'h00}, 6'h3E, 1, "R2 base bit8 mismatch");
    no_ack({base ^ 16'h8000, 8'h04}, 6'h3E, 1, "R2 base bit23 mismatch");
    check(dcode == 5'h1F && !tdis, "R2 no write effect", {26'd0, tdis, dcode}, {26'd0, 1'b0, 5'h1F});

    // R5 control write
    snap = n_trig;
    bus(8'h04, 6'h3E, 1, 32'h0000_0005, 0, "R5 trig+dis", 3);
    check(n_trig == snap + 1, "R5 one trigger pulse", n_trig - snap, 1);
    check(tdis, "R5 disable set", {31'd0, tdis}, 1);
    bus(8'h04, 6'h3E, 1, 32'h0000_0000, 0, "R5 clear", 0);
    check(n_trig == snap + 1 && !tdis, "R5 bit0=0 no trigger", {n_trig - snap}, 1);
    bus(8'h04, 6'h3E, 1, 32'h0000_0004, 0, "R5 dis only", 0);

    // R6 status read, while busy (R9 registers still served)
    busy = 1; rx_ready = 1; tcnt = 12'hABC; full = 0; empty = 1; fcnt = 12'h123;
    bus(8'h04, 6'h3E, 0, 0, 32'h1232_ABC7, "R6/R9 status read busy", 0);
    full = 1; empty = 0; busy = 0; rx_ready = 0;
    bus(8'h04, 6'h3E, 0, 0, 32'h1231_ABC4, "R6 status read idle", 0);

    // R9 FIFO blocked while busy
    busy = 1; snap = n_wr;
    no_ack({base, 8'h10}, 6'h3E, 1, "R9 fifo write busy no ack");
    check(n_wr == snap, "R9 no push while busy", n_wr - snap, 0);
    frd = 32'h600D_BEEF; snap = n_rd;
    @(negedge clk);
    addr = {base, 8'h10}; am = 6'h3E; wr = 0; as_s = 1; ds_s = 1;
    exp_q.push_back(32'h600D_BEEF); tag_q.push_back("R9 held fifo read data");
    repeat (4) @(negedge clk);
    check(!ack && n_rd == snap, "R9 read stalled", {31'd0, ack}, 0);
    busy = 0; got = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (ack) begin got = 1; break; end end
    check(got, "R9 ack after busy drops", {31'd0, got}, 1);
    as_s = 0; ds_s = 0;
    repeat (2) @(negedge clk);
    check(n_rd == snap + 1, "R9 single pop", n_rd - snap, 1);

    // R8 FIFO port idle
    snap = n_wr;
    bus(8'h10, 6'h3E, 1, 32'h1234_5678, 0, "R8 push", 2);
    check(n_wr == snap + 1 && last_fwd == 32'h1234_5678, "R8 push data", last_fwd, 32'h1234_5678);
    frd = 32'hCAFE_F00D; snap = n_rd;
    bus(8'h10, 6'h39, 0, 0, 32'hCAFE_F00D, "R8 pop data", 4);
    check(n_rd == snap + 1, "R8/R3 single pop on long strobe", n_rd - snap, 1);

    // R10 unmapped offsets
    bus(8'h0C, 6'h3E, 1, 32'hFFFF_FFFF, 0, "R10 wr 0C", 0);
    bus(8'h20, 6'h3E, 1, 32'h0000_0000, 0, "R10 wr 20", 0);
    bus(8'h0C, 6'h3E, 0, 0, 32'h0, "R10 rd 0C zero", 0);
    bus(8'h14, 6'h3E, 0, 0, 32'h0, "R10 rd 14 zero", 0);
    bus(8'h00, 6'h3E, 0, 0, 32'hC35A_B3FF, "R10 cfg unchanged", 0);

    // R7 reset register
    bus(8'h08, 6'h3E, 1, 32'h0000_0002, 0, "R7 rx reset on", 0);
    check(rxrst, "R7 rx_reset level", {31'd0, rxrst}, 1);
    bus(8'h08, 6'h3E, 0, 0, 32'h0000_0002, "R7 readback", 0);
    snap = n_mrst;
    bus(8'h08, 6'h3E, 1, 32'h0000_0001, 0, "R7 module reset", 0);
    check(n_mrst == snap + 1, "R7 one reset pulse", n_mrst - snap, 1);
    check(!rxrst && !tdis && dcode == 0 && hlim == 0, "R7 fields cleared", {24'd0, hlim}, 0);
    bus(8'h00, 6'h3E, 0, 0, 32'h0000_B000, "R7 cfg after reset", 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads acknowledged", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule